// File: doc/BRIEF.md
# Accumulator Processor with NOR, ADD, Store and Carry-Conditional Jump

This block is a tiny 8-bit processor built around a single accumulator. Its instruction set has four entries. Two of them combine the accumulator with a memory byte, either by bitwise NOR or by addition with carry out. One writes the accumulator back to memory. The last is a branch that is taken only when the carry flag is clear. When the flag is set, this branch does not jump; it clears the flag and execution falls through.

Instructions and data share one 64-byte memory, which sits outside the block behind a synchronous port with one cycle of read latency. A small state machine steps through fetch, decode, operand fetch, execute, store and jump. It inserts a wait state after every read so that the returned byte is captured cleanly. Debug outputs carry the program counter, the accumulator, the carry flag and the state code. The state code is 0 exactly at the first cycle of each instruction, so a testbench can compare the architectural state at every instruction boundary.

Top module: `accnor_cpu`

## Requirements
- R1: An instruction byte carries the opcode in bits [7:6] and a 6-bit address or jump target in bits [5:0]. All memory operands and store destinations use that 6-bit field as the address.
- R2: Opcode 00 sets the accumulator to the bitwise NOR of the accumulator and the memory byte at the field address. The carry is left unchanged.
- R3: Opcode 01 sets the accumulator to the low 8 bits of the sum of the accumulator and the memory byte. The carry becomes the ninth bit of that sum.
- R4: Opcode 10 writes the accumulator to memory at the field address. The accumulator and carry are left unchanged, and the write enable is high for one cycle only.
- R5: Opcode 11 with the carry at 0 loads the program counter with the 6-bit target.
- R6: Opcode 11 with the carry at 1 clears the carry and continues at the next address.
- R7: While reset is low, the program counter, accumulator and carry read 0 and the state code reads 0 (fetch).
- R8: The program counter advances by one, modulo 64, after each instruction fetch, so it wraps from 63 to 0.
- R9: Measured from one fetch state to the next, NOR and ADD take 6 cycles each, and store and jump take 4 cycles each.
- R10: Start from reset with the program NOR 8, ADD 7, STA 6, JCC 4, JCC 4 at addresses 0 to 4, and with 0x7E at address 7 and 0xFF at address 8. The program writes 0x7E to address 6, takes the first jump with the carry at 0, and then stays at address 4.
- R11: The memory enable is high only in cycles that issue a read or a write, and the write enable is never high without the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 6 | Memory address (program counter or instruction field) |
| mem_wdata | output | 8 | Data written to memory |
| mem_rdata | input | 8 | Data read from memory, valid one cycle after a read |
| mem_we | output | 1 | Memory write enable |
| mem_en | output | 1 | Memory access enable |
| dbg_pc | output | 6 | Current program counter |
| dbg_acc | output | 8 | Current accumulator |
| dbg_carry | output | 1 | Current carry flag |
| dbg_state | output | 3 | Controller state code, 0 = fetch |

## Verification
The reference results of an instruction are due at the next cycle in which the state code returns to 0. For NOR and ADD that is 6 cycles after the fetch cycle; for store and jump it is 4 cycles. Memory written by a store is visible in that same boundary cycle. The bench waits, on falling edges, for the state code to return to 0 and counts the cycles as it waits. At that point it compares the counter, accumulator, carry and elapsed cycle count against an instruction-level model. At the end of each program it compares the entire memory image.

// File: rtl/accnor_cpu.sv
module accnor_cpu #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-3:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic              mem_en,
  output logic [DATA_W-3:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_acc,
  output logic              dbg_carry,
  output logic [2:0]        dbg_state
);
  localparam int ADDR_W = DATA_W - 2;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_IRLD  = 3'd1,
    ST_DEC   = 3'd2,
    ST_OPRD  = 3'd3,
    ST_OPLD  = 3'd4,
    ST_EXEC  = 3'd5,
    ST_STORE = 3'd6,
    ST_JUMP  = 3'd7
  } state_t;

  state_t             state, state_nx;
  logic [ADDR_W-1:0]  pc;
  logic [DATA_W-1:0]  ir, opnd, acc;
  logic               carry;
  logic [1:0]         opc;
  logic [ADDR_W-1:0]  field;
  logic [DATA_W:0]    sum;
  logic [DATA_W-1:0]  alu_y;
  logic               ld_ir, ld_opnd, ld_acc, ld_c, clr_c, ld_pc, sel_field;

  assign opc   = ir[DATA_W-1:ADDR_W];
  assign field = ir[ADDR_W-1:0];

  assign ld_ir     = (state == ST_IRLD);
  assign ld_opnd   = (state == ST_OPLD);
  assign ld_acc    = (state == ST_EXEC);
  assign ld_c      = (state == ST_EXEC) && opc[0];
  assign clr_c     = (state == ST_JUMP) && carry;
  assign ld_pc     = (state == ST_JUMP) && !carry;
  assign sel_field = (state == ST_OPRD) || (state == ST_STORE);

  assign sum   = {1'b0, acc} + {1'b0, opnd};
  assign alu_y = opc[0] ? sum[DATA_W-1:0] : ~(acc | opnd);

  assign mem_addr  = sel_field ? field : pc;
  assign mem_wdata = acc;
  assign mem_we    = (state == ST_STORE);
  assign mem_en    = (state == ST_FETCH) || (state == ST_OPRD) || (state == ST_STORE);

  assign dbg_pc    = pc;
  assign dbg_acc   = acc;
  assign dbg_carry = carry;
  assign dbg_state = state;

  always_comb begin
    state_nx = state;
    case (state)
      ST_FETCH: state_nx = ST_IRLD;
      ST_IRLD:  state_nx = ST_DEC;
      ST_DEC: begin
        case (opc)
          2'b10:   state_nx = ST_STORE;
          2'b11:   state_nx = ST_JUMP;
          default: state_nx = ST_OPRD;
        endcase
      end
      ST_OPRD:  state_nx = ST_OPLD;
      ST_OPLD:  state_nx = ST_EXEC;
      default:  state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
      opnd  <= '0;
      acc   <= '0;
      carry <= 1'b0;
    end else begin
      state <= state_nx;
      if (ld_ir)        ir   <= mem_rdata;
      if (ld_ir)        pc   <= pc + 1'b1;
      else if (ld_pc)   pc   <= field;
      if (ld_opnd)      opnd <= mem_rdata;
      if (ld_acc)       acc  <= alu_y;
      if (ld_c)         carry <= sum[DATA_W];
      else if (clr_c)   carry <= 1'b0;
    end
  end
endmodule

// File: rtl/accnor_cpu_chk.sv
module accnor_cpu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic              mem_en,
  input logic [DATA_W-3:0] dbg_pc,
  input logic [DATA_W-1:0] dbg_acc,
  input logic              dbg_carry,
  input logic [2:0]        dbg_state
);
  // R11
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 3'd1) |=> (dbg_pc == $past(dbg_pc) + 1'b1));

  // R2
  acc_only_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbg_acc) |-> ($past(dbg_state) == 3'd5));

  // R3
  carry_rise_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_carry) |-> ($past(dbg_state) == 3'd5));

  // R6
  carry_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbg_carry) |-> ($past(dbg_state) == 3'd5 || $past(dbg_state) == 3'd7));

  // R9
  fetch_then_irld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 3'd0) |=> (dbg_state == 3'd1));
endmodule

bind accnor_cpu accnor_cpu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_en(mem_en),
  .dbg_pc(dbg_pc), .dbg_acc(dbg_acc), .dbg_carry(dbg_carry), .dbg_state(dbg_state)
);

// File: tb/tb_accnor_cpu.sv
module tb_accnor_cpu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic       mem_we, mem_en;
  logic [5:0] dbg_pc;
  logic [7:0] dbg_acc;
  logic       dbg_carry;
  logic [2:0] dbg_state;

  logic [7:0] mem [64];
  logic [7:0] rmem [64];
  logic [5:0] r_pc;
  logic [7:0] r_acc;
  logic       r_c;
  int n_chk = 0, n_bad = 0, stray = 0;
  bit done = 0;

  always #5 clk = ~clk;

  accnor_cpu dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_en(mem_en), .dbg_pc(dbg_pc),
    .dbg_acc(dbg_acc), .dbg_carry(dbg_carry), .dbg_state(dbg_state)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  // R11 monitor
  always @(negedge clk) if (rst_n && ((mem_we && !mem_en) ||
      (mem_en && !(dbg_state == 3'd0 || dbg_state == 3'd3 || dbg_state == 3'd6)))) stray++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 pc", dbg_pc, 0);
    check("R7 acc", dbg_acc, 0);
    check("R7 carry", dbg_carry, 0);
    check("R7 state", dbg_state, 0);
    r_pc = 0; r_acc = 0; r_c = 0;
    foreach (mem[i]) rmem[i] = mem[i];
    rst_n = 1'b1;
  endtask

  task automatic step(output int exp_cyc, output string tag);
    logic [7:0] ins = rmem[r_pc];
    logic [5:0] a = ins[5:0];
    logic [5:0] npc = r_pc + 6'd1;
    case (ins[7:6])
      2'b00: begin r_acc = ~(r_acc | rmem[a]); exp_cyc = 6; tag = "R2"; end
      2'b01: begin {r_c, r_acc} = {1'b0, r_acc} + {1'b0, rmem[a]}; exp_cyc = 6; tag = "R3"; end
      2'b10: begin rmem[a] = r_acc; exp_cyc = 4; tag = "R4"; end
      default: begin
        if (!r_c) begin npc = a; tag = "R5"; end
        else begin r_c = 1'b0; tag = "R6"; end
        exp_cyc = 4;
      end
    endcase
    r_pc = npc;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      int exp_cyc, cyc;
      string tag;
      step(exp_cyc, tag);
      cyc = 0;
      do begin @(negedge clk); cyc++; end while (dbg_state != 3'd0 && cyc < 20);
      check("R9 cycles", cyc, exp_cyc);
      check({tag, " R8 pc"}, dbg_pc, r_pc);
      check({tag, " acc"}, dbg_acc, r_acc);
      check({tag, " carry"}, dbg_carry, r_c);
    end
  endtask

  task automatic mem_cmp(string req);
    int diff = 0;
    foreach (mem[i]) if (mem[i] !== rmem[i]) diff++;
    check(req, diff, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h0ACC_0123));
    // R10 sample program
    foreach (mem[i]) mem[i] = 8'h00;
    mem[0] = 8'h08; mem[1] = 8'h47; mem[2] = 8'h86; mem[3] = 8'hC4; mem[4] = 8'hC4;
    mem[7] = 8'h7E; mem[8] = 8'hFF;
    do_reset();
    run(8);
    check("R10 mem6", mem[6], 8'h7E);
    check("R10 loop pc", dbg_pc, 6'd4);
    mem_cmp("R1 R10 image");

    // R8 wrap: jump to 63, NOR there, fall through to 0
    foreach (mem[i]) mem[i] = 8'h00;
    mem[0] = 8'hFF; mem[63] = 8'h3E; mem[62] = 8'h55;
    do_reset();
    run(2);
    check("R8 wrap pc", dbg_pc, 6'd0);
    check("R2 nor", dbg_acc, 8'hAA);

    // R3/R6 carry set then jump falls through and clears carry
    foreach (mem[i]) mem[i] = 8'h00;
    mem[0] = 8'h0B; mem[1] = 8'h4A; mem[2] = 8'hC5; mem[3] = 8'hC0;
    mem[10] = 8'hFF; mem[11] = 8'h00;
    do_reset();
    run(2);
    check("R3 sum", dbg_acc, 8'hFE);
    check("R3 carry", dbg_carry, 1'b1);
    run(1);
    check("R6 pc", dbg_pc, 6'd3);
    check("R6 carry", dbg_carry, 1'b0);
    run(1);
    check("R5 pc", dbg_pc, 6'd0);

    // random programs, with reset mid-run (R7)
    for (int p = 0; p < 6; p++) begin
      foreach (mem[i]) mem[i] = 8'($urandom);
      do_reset();
      run(80);
      mem_cmp("R1 R4 image");
    end

    n_chk++;
    if (stray != 0) begin
      n_bad++;
      $display("FAIL R11 stray enables actual=%0d expected=0", stray);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule